// File: doc/BRIEF.md
# Retention Power Domain with Isolation

This block models a switchable power domain. The domain holds a bank of word-wide retention registers. A sequencing controller sits beside it, and isolation clamps sit at its outputs. A sleep request starts a fixed entry sequence. The controller first strobes a save so that each register copies its value into an always-powered shadow latch. It then raises isolation, and only after that does it cut domain power. While the domain is unpowered the main storage is treated as undefined. The shadow latch keeps the saved word.

A wake request restores power and waits a programmable number of settle cycles. The controller then strobes a restore that loads every register from its shadow latch, and it releases isolation on the next cycle. Downstream logic never sees the undefined contents, because each output bit is forced to its own elaboration-time constant while isolation is on. The four power-control pins (save, restore, isolation, sleep) each have an idle level that is set by a parameter. A two-bit status output reports the phase of the sequence.

Top module: `pg_domain`

## Requirements
- R1: After reset, status_o is 0 (active), every control pin sits at its idle level, and every register word reads 0.
- R2: In the active state, asserting wr_en_i writes wr_data_i into the word selected by wr_addr_i. The new value appears on the matching slice of dom_q_o (word i at bits i*DATA_W upward) one cycle later. Other words are unchanged.
- R3: A sleep_req_i sampled while active gives the following cycle sequence. One cycle has status 1 with only save asserted. The next cycle has status 1 with only isolation asserted. From the cycle after that, status is 2 with isolation and sleep asserted.
- R4: Whenever isolation is asserted, every bit of dom_q_o equals the matching bit of CLAMP_VAL.
- R5: A write presented while the status is not active has no effect on register contents.
- R6: A wake_req_i sampled while asleep gives the following sequence. On the next cycle status is 3, sleep is released and isolation stays asserted. Restore is asserted for exactly one cycle, settle_cycles_i+1 cycles after that first waking cycle. On the cycle after restore, status is 0 and isolation is released.
- R7: After wake, dom_q_o shows the register values held at sleep entry, including a write issued in the same cycle as the sleep request.
- R8: A wake_req_i sampled during sleep entry (status 1) is remembered. The asleep state then lasts exactly one cycle before waking begins.
- R9: Each control pin equals its PIN_IDLE bit when inactive and the complement when active. PIN_IDLE bit 0 is save, bit 1 restore, bit 2 isolation, bit 3 sleep.
- R10: dom_q_o and status_o never carry an unknown value after reset.
- R11: wake_req_i while active and sleep_req_i while asleep are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Request to enter sleep |
| wake_req_i | input | 1 | Request to wake |
| settle_cycles_i | input | CNT_W | Extra settle cycles before restore |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | ADDR_W | Register word select |
| wr_data_i | input | DATA_W | Write data |
| dom_q_o | output | NUM_REGS*DATA_W | Isolated register outputs |
| save_pin_o | output | 1 | Save control pin |
| restore_pin_o | output | 1 | Restore control pin |
| iso_pin_o | output | 1 | Isolation control pin |
| sleep_pin_o | output | 1 | Power switch control pin (active means power off) |
| status_o | output | 2 | 0 active, 1 entering sleep, 2 asleep, 3 waking |

## Verification
A controller that drops power before isolation, or that releases isolation before the restore, exposes unknown or stale data on dom_q_o within one cycle of the misordered step. A missing or misplaced save, or a restore that loads the wrong latch, leaves dom_q_o wrong on the first active cycle after wake. Off-by-one errors in the settle counter or in pending-wake tracking move the restore pin or the status change by one cycle. The cycle-exact checks on the pins and status catch that shift.

// File: rtl/pg_domain_pkg.sv
package pg_domain_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE, ST_SAVE, ST_ISO, ST_ASLEEP, ST_SETTLE, ST_RESTORE
  } pg_state_e;

  typedef enum logic [1:0] {
    STAT_ACTIVE = 2'd0,
    STAT_ENTER  = 2'd1,
    STAT_ASLEEP = 2'd2,
    STAT_WAKE   = 2'd3
  } pg_status_e;

  localparam int PIN_SAVE    = 0;
  localparam int PIN_RESTORE = 1;
  localparam int PIN_ISO     = 2;
  localparam int PIN_SLEEP   = 3;
  localparam int NUM_PINS    = 4;
endpackage

// File: rtl/pg_seq_ctrl.sv
module pg_seq_ctrl
  import pg_domain_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_req_i,
  input  logic             wake_req_i,
  input  logic [CNT_W-1:0] settle_cycles_i,
  output logic             save_o,
  output logic             restore_o,
  output logic             iso_o,
  output logic             pwr_off_o,
  output logic             wr_ok_o,
  output logic [1:0]       status_o
);
  pg_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             wake_pend_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE:  if (sleep_req_i) state_d = ST_SAVE;
      ST_SAVE:    state_d = ST_ISO;
      ST_ISO:     state_d = ST_ASLEEP;
      ST_ASLEEP:  if (wake_req_i || wake_pend_q) state_d = ST_SETTLE;
      ST_SETTLE:  if (cnt_q == '0) state_d = ST_RESTORE;
      ST_RESTORE: state_d = ST_ACTIVE;
      default:    state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_ACTIVE;
      cnt_q       <= '0;
      wake_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_ASLEEP && state_d == ST_SETTLE) cnt_q <= settle_cycles_i;
      else if (state_q == ST_SETTLE && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      // wake seen mid-entry is parked until asleep
      if ((state_q == ST_SAVE || state_q == ST_ISO) && wake_req_i) wake_pend_q <= 1'b1;
      else if (state_q == ST_ASLEEP)                               wake_pend_q <= 1'b0;
    end
  end

  always_comb begin
    save_o    = (state_q == ST_SAVE);
    restore_o = (state_q == ST_RESTORE);
    pwr_off_o = (state_q == ST_ASLEEP);
    iso_o     = (state_q == ST_ISO) || (state_q == ST_ASLEEP) ||
                (state_q == ST_SETTLE) || (state_q == ST_RESTORE);
    wr_ok_o   = (state_q == ST_ACTIVE);
    unique case (state_q)
      ST_ACTIVE:            status_o = STAT_ACTIVE;
      ST_SAVE, ST_ISO:      status_o = STAT_ENTER;
      ST_ASLEEP:            status_o = STAT_ASLEEP;
      ST_SETTLE, ST_RESTORE: status_o = STAT_WAKE;
      default:              status_o = STAT_ACTIVE;
    endcase
  end
endmodule

// File: rtl/pg_ret_word.sv
module pg_ret_word #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_off_i,
  input  logic              save_i,
  input  logic              restore_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] main_q;
  logic [DATA_W-1:0] shadow_q;

  // always-on shadow latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= '0;
    else if (save_i) shadow_q <= main_q;
  end

  // switched storage: undefined while unpowered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         main_q <= '0;
    else if (pwr_off_i)  main_q <= 'x;
    else if (restore_i)  main_q <= shadow_q;
    else if (wr_en_i)    main_q <= wr_data_i;
  end

  assign q_o = main_q;
endmodule

// File: rtl/pg_iso_clamp.sv
module pg_iso_clamp #(
  parameter int           W     = 32,
  parameter logic [W-1:0] CLAMP = '0
) (
  input  logic         iso_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (CLAMP[b]) begin : g_hi
      assign q_o[b] = d_i[b] | iso_i;
    end else begin : g_lo
      assign q_o[b] = d_i[b] & ~iso_i;
    end
  end
endmodule

// File: rtl/pg_domain.sv
module pg_domain
  import pg_domain_pkg::*;
#(
  parameter int                         NUM_REGS  = 4,
  parameter int                         DATA_W    = 8,
  parameter int                         CNT_W     = 4,
  parameter logic [NUM_REGS*DATA_W-1:0] CLAMP_VAL = '0,
  parameter logic [NUM_PINS-1:0]        PIN_IDLE  = '0,
  localparam int                        ADDR_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int                        OUT_W     = NUM_REGS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_req_i,
  input  logic              wake_req_i,
  input  logic [CNT_W-1:0]  settle_cycles_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [OUT_W-1:0]  dom_q_o,
  output logic              save_pin_o,
  output logic              restore_pin_o,
  output logic              iso_pin_o,
  output logic              sleep_pin_o,
  output logic [1:0]        status_o
);
  logic save_act, restore_act, iso_act, pwr_off, wr_ok;
  logic [OUT_W-1:0]    raw_q;
  logic [NUM_PINS-1:0] pin_act, pin_lvl;

  pg_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sleep_req_i    (sleep_req_i),
    .wake_req_i     (wake_req_i),
    .settle_cycles_i(settle_cycles_i),
    .save_o         (save_act),
    .restore_o      (restore_act),
    .iso_o          (iso_act),
    .pwr_off_o      (pwr_off),
    .wr_ok_o        (wr_ok),
    .status_o       (status_o)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    logic word_we;
    assign word_we = wr_en_i && wr_ok && (wr_addr_i == ADDR_W'(i));
    pg_ret_word #(.DATA_W(DATA_W)) u_word (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pwr_off_i(pwr_off),
      .save_i   (save_act),
      .restore_i(restore_act),
      .wr_en_i  (word_we),
      .wr_data_i(wr_data_i),
      .q_o      (raw_q[i*DATA_W +: DATA_W])
    );
  end

  pg_iso_clamp #(.W(OUT_W), .CLAMP(CLAMP_VAL)) u_clamp (
    .iso_i(iso_act),
    .d_i  (raw_q),
    .q_o  (dom_q_o)
  );

  assign pin_act[PIN_SAVE]    = save_act;
  assign pin_act[PIN_RESTORE] = restore_act;
  assign pin_act[PIN_ISO]     = iso_act;
  assign pin_act[PIN_SLEEP]   = pwr_off;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pin_lvl[p] = PIN_IDLE[p] ? ~pin_act[p] : pin_act[p];
  end

  assign save_pin_o    = pin_lvl[PIN_SAVE];
  assign restore_pin_o = pin_lvl[PIN_RESTORE];
  assign iso_pin_o     = pin_lvl[PIN_ISO];
  assign sleep_pin_o   = pin_lvl[PIN_SLEEP];
endmodule

// File: rtl/pg_domain_chk.sv
module pg_domain_chk #(
  parameter int           W     = 32,
  parameter logic [W-1:0] CLAMP = '0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         save_act,
  input logic         restore_act,
  input logic         iso_act,
  input logic         pwr_off,
  input logic [1:0]   status_o,
  input logic [W-1:0] dom_q_o
);
  assert_save_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_act |=> !save_act && iso_act && !pwr_off);

  assert_off_needs_iso_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_off |-> iso_act && status_o == 2'd2);

  assert_clamp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso_act |-> dom_q_o == CLAMP);

  assert_restore_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_act |=> !iso_act && !restore_act && status_o == 2'd0);

  assert_restore_after_iso_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_act |-> $past(iso_act) && !pwr_off);

  assert_no_x_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({status_o, dom_q_o}));
endmodule

bind pg_domain pg_domain_chk #(.W(NUM_REGS*DATA_W), .CLAMP(CLAMP_VAL)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .save_act   (save_act),
  .restore_act(restore_act),
  .iso_act    (iso_act),
  .pwr_off    (pwr_off),
  .status_o   (status_o),
  .dom_q_o    (dom_q_o)
);

// File: tb/pg_domain_tb.sv
module pg_domain_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          NREG = 4;
  localparam int          DW = 8;
  localparam int          W = NREG * DW;
  localparam logic [W-1:0] CLAMP = 32'hC3A5_0FF0;
  localparam logic [3:0]  IDLE = 4'b0110;

  typedef struct {
    int           cyc;
    int           kind;   // 0 status, 1 pins, 2 data
    logic [W-1:0] val;
    string        req;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 0, wake_req = 0, wr_en = 0;
  logic [3:0] settle = 0;
  logic [1:0] addr = 0;
  logic [DW-1:0] wdata = 0;
  logic [W-1:0] dom_q;
  logic save_p, rest_p, iso_p, sleep_p;
  logic [1:0] status;

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit x_seen = 0;
  item_t sb_q[$];
  item_t mon_it;
  logic [W-1:0] mdl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pg_domain #(.NUM_REGS(NREG), .DATA_W(DW), .CNT_W(4), .CLAMP_VAL(CLAMP), .PIN_IDLE(IDLE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .wake_req_i(wake_req),
    .settle_cycles_i(settle), .wr_en_i(wr_en), .wr_addr_i(addr), .wr_data_i(wdata),
    .dom_q_o(dom_q), .save_pin_o(save_p), .restore_pin_o(rest_p), .iso_pin_o(iso_p),
    .sleep_pin_o(sleep_p), .status_o(status)
  );

  function automatic logic [3:0] pins(bit s, bit r, bit i, bit sl);
    return {sl, i, r, s} ^ IDLE;
  endfunction

  task automatic push(int off, int kind, logic [W-1:0] v, string req);
    sb_q.push_back('{cyc + off, kind, v, req});
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write(int a, logic [DW-1:0] d);
    wr_en = 1; addr = 2'(a); wdata = d;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if ($isunknown({status, dom_q, save_p, rest_p, iso_p, sleep_p})) x_seen = 1;
      while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
        logic [W-1:0] act;
        mon_it = sb_q.pop_front();
        case (mon_it.kind)
          0:       act = W'(status);
          1:       act = W'({sleep_p, iso_p, rest_p, save_p});
          default: act = dom_q;
        endcase
        n_chk++;
        if (act !== mon_it.val || mon_it.cyc != cyc) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h (cycle %0d)", mon_it.req, act, mon_it.val, cyc);
        end
      end
    end
  end

  task automatic finish_run();
    n_chk++;
    if (x_seen) begin n_fail++; $display("FAIL R10: actual unknown seen expected none"); end
    n_chk++;
    if (sb_q.size() != 0) begin n_fail++; $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size()); end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    // R1 reset state, R9 idle levels
    push(1, 0, 0, "R1 status");
    push(1, 1, W'(pins(0,0,0,0)), "R1 R9 idle pins");
    push(1, 2, 0, "R1 data");
    step();

    // R2 writes
    for (int i = 0; i < NREG; i++) begin
      logic [DW-1:0] d = DW'(8'h11 * (i + 1) + 8'h08);
      write(i, d);
      mdl[i*DW +: DW] = d;
      push(1, 2, mdl, "R2 write");
      step();
    end
    write(1, 8'h5A); mdl[1*DW +: DW] = 8'h5A;
    push(1, 2, mdl, "R2 overwrite");
    step();
    wr_en = 0;

    // R11 wake while active ignored
    wake_req = 1;
    push(1, 0, 0, "R11 wake in active");
    step();
    wake_req = 0;
    step();

    // R3 sleep entry with same-cycle write (R7)
    sleep_req = 1; write(2, 8'hE7); mdl[2*DW +: DW] = 8'hE7;
    push(1, 0, 1, "R3 enter status");
    push(1, 1, W'(pins(1,0,0,0)), "R3 R9 save pin");
    push(1, 2, mdl, "R3 data before iso");
    push(2, 0, 1, "R3 iso status");
    push(2, 1, W'(pins(0,0,1,0)), "R3 R9 iso pin");
    push(2, 2, CLAMP, "R4 clamp in iso");
    push(3, 0, 2, "R3 asleep status");
    push(3, 1, W'(pins(0,0,1,1)), "R3 R9 sleep pin");
    push(3, 2, CLAMP, "R4 clamp asleep");
    step();
    sleep_req = 0; wr_en = 0;
    step(); step();

    // R5 write and R11 sleep while asleep ignored
    write(0, 8'hFF); sleep_req = 1; settle = 4'd3;
    push(1, 0, 2, "R11 stays asleep");
    push(1, 2, CLAMP, "R4 clamp asleep 2");
    step();
    wr_en = 0; sleep_req = 0;

    // R6 wake, settle 3
    wake_req = 1;
    push(1, 0, 3, "R6 waking status");
    push(1, 1, W'(pins(0,0,1,0)), "R6 power back on");
    push(1, 2, CLAMP, "R4 clamp waking");
    push(4, 1, W'(pins(0,0,1,0)), "R6 no early restore");
    push(5, 1, W'(pins(0,1,1,0)), "R6 restore pulse");
    push(5, 0, 3, "R6 restore status");
    push(6, 0, 0, "R6 active again");
    push(6, 1, W'(pins(0,0,0,0)), "R6 iso released");
    push(6, 2, mdl, "R7 R5 restored data");
    step();
    wake_req = 0;
    repeat (6) step();

    // R8 wake during entry, settle 0
    settle = 4'd0;
    sleep_req = 1;
    push(1, 0, 1, "R8 entering");
    step();
    sleep_req = 0; wake_req = 1;
    push(2, 0, 2, "R8 asleep one cycle");
    push(3, 0, 3, "R8 waking");
    push(4, 1, W'(pins(0,1,1,0)), "R8 restore settle 0");
    push(5, 0, 0, "R8 active");
    push(5, 2, mdl, "R8 R7 data");
    step();
    wake_req = 0;
    repeat (5) step();

    // R2 after wake
    write(3, 8'h3C); mdl[3*DW +: DW] = 8'h3C;
    push(1, 2, mdl, "R2 write after wake");
    step();
    wr_en = 0;
    repeat (4) step();
    finish_run();
  end
endmodule